// File: doc/BRIEF.md
# Switching Clock Synchronization Sequencer

This block produces the switching-clock pulse train of a power converter from a fast system clock. With no external reference it emits a one-clock pulse every `default_period` system clocks. When rising edges appear on an external sync input, it first confirms that the input is genuine, then waits a long qualification count, and then moves the switching period over to the measured sync period without a glitch. After that move it nudges the switching phase a little on each sync edge until switching pulses line up with the sync edges, and then it reports lock.

A spread-spectrum enable is raised from the first sync edge until the period handover, so an external modulator can dither the clock while the reference is still being qualified. A reduced-frequency flag from the converter's protection logic holds off the handover for as long as it is high. If the sync input goes quiet for too long, the sequencer falls back to the default period and starts qualifying again from scratch. All pins are plain control and status signals: there is no data stream, so no valid/ready handshake is used.

Top module: `sw_sync_seq`

## Requirements
- R1: After reset the state code is 0, `ss_en` and `locked` are low, and `sw_pulse` is high for one system clock every `default_period` clocks (the period must be at least 4).
- R2: The first rising edge on `sync_in` (seen through a two-flop synchronizer, so it acts two clocks after it occurs) moves the state code to 1 and raises `ss_en`.
- R3: The fourth rising sync edge, counted from the first, moves the state code from 1 to 2; after three edges it is still 1.
- R4: In state 2, the HANDOVER_EDGES-th rising sync edge (2048 by default) moves the state code to 3. From then on, the switching period is the latest measured sync period, which is the count of system clocks between the last two rising sync edges.
- R5: `ss_en` is high exactly while the state code is 1 or 2. It falls at the handover edge and on loss of sync.
- R6: The cycle in progress at the handover keeps its elapsed count e. Its total length becomes e + floor(N*(L-e)/L), where L is the old period and N the new one, with at least one more clock. So every switching interval lies between min(L,N) and max(L,N), widened only by the correction step of R7.
- R7: In states 3 and 4, each rising sync edge changes the length of the switching cycle in progress by at most max(1, N/32) system clocks. A cycle is lengthened if the edge falls in its first half and shortened if it falls in its second half.
- R8: The state code becomes 4 and `locked` rises after 4 consecutive sync edges whose distance to the nearest switching pulse is at most 2 clocks. Once locked, every synchronized sync edge lies within 2 clocks of a `sw_pulse`, and the interval between pulses settles to the sync period.
- R9: While `reduced_freq` is high, the sequencer stays in state 2 even after the handover count has been reached. The handover happens on the first rising sync edge after the flag clears.
- R10: In any state other than 0, if no rising sync edge arrives for 4 x `default_period` clocks, the state code returns to 0 and `locked` and `ss_en` fall. The period reverts to `default_period`, and four fresh edges are again needed to reach state 2.
- R11: State code values: 0 idle, 1 detecting, 2 counting toward handover, 3 phase adjusting, 4 locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | External synchronization input, asynchronous |
| default_period | input | CNT_W | Switching period in system clocks when not synchronized |
| reduced_freq | input | 1 | High while the converter runs at reduced frequency; holds off the handover |
| sw_pulse | output | 1 | One-clock pulse at the start of each switching cycle |
| ss_en | output | 1 | Spread-spectrum enable |
| locked | output | 1 | Phase lock achieved |
| state_code | output | 3 | Sequencer state (R11 encoding) |

## Verification
The main path is tried with a sync period drawn at random above the default period and a random starting phase. It is also tried with a directed sync period below the default. The first case makes the handover cycle stretch and the second makes it shrink, and a continuous interval monitor checks both against the R6 and R7 bounds. Holding the reduced-frequency flag past the handover count separates a sequencer that merely counts edges from one that honours the hold. Stopping the sync input after lock, then restarting it with only three edges, shows that the fallback restores the default period and restarts qualification from zero instead of resuming it.

// File: rtl/sw_sync_pkg.sv
`timescale 1ns/1ps
package sw_sync_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DETECT = 3'd1,
    ST_WAIT   = 3'd2,
    ST_PHASE  = 3'd3,
    ST_LOCKED = 3'd4
  } seq_state_e;
endpackage

// File: rtl/sync_edge_det.sv
`timescale 1ns/1ps
// Synchronizes an asynchronous input and flags its rising edges.
module sync_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic rise
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], d_in};
  end

  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/sync_period_meter.sv
`timescale 1ns/1ps
// Measures clocks between rising sync edges and flags a silent input.
module sync_period_meter #(
  parameter int CNT_W        = 16,
  parameter int LOSS_PERIODS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic [CNT_W-1:0] default_period,
  output logic [CNT_W-1:0] meas_period,
  output logic             lost
);
  localparam int SW = CNT_W + $clog2(LOSS_PERIODS) + 1;

  logic [SW-1:0] since_cnt;
  logic [SW-1:0] loss_limit;

  assign loss_limit = SW'(default_period) * SW'(LOSS_PERIODS);
  assign lost       = since_cnt >= loss_limit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_cnt   <= '0;
      meas_period <= '0;
    end else if (rise) begin
      since_cnt   <= SW'(1);
      meas_period <= (since_cnt > SW'({CNT_W{1'b1}})) ? {CNT_W{1'b1}} : CNT_W'(since_cnt);
    end else if (since_cnt != {SW{1'b1}}) begin
      since_cnt <= since_cnt + SW'(1);
    end
  end

  // R4: a new measurement is taken only on a rising sync edge
  assert_meas_on_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(meas_period));
endmodule

// File: rtl/sw_pulse_gen.sv
`timescale 1ns/1ps
// Phase counter emitting one pulse per switching cycle; the length of the
// cycle in progress can be rewritten while it runs.
module sw_pulse_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] next_len,
  input  logic             adj_valid,
  input  logic [CNT_W-1:0] adj_len,
  output logic [CNT_W-1:0] phase_cnt,
  output logic [CNT_W-1:0] cur_len,
  output logic             wrap,
  output logic             sw_pulse
);
  assign wrap     = ({1'b0, phase_cnt} + 1'b1) >= {1'b0, cur_len};
  assign sw_pulse = (phase_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_cnt <= '0;
      cur_len   <= next_len;
    end else if (wrap) begin
      phase_cnt <= '0;
      cur_len   <= next_len;
    end else begin
      phase_cnt <= phase_cnt + 1'b1;
      if (adj_valid) cur_len <= adj_len;
    end
  end

  // R6: a rewritten length always ends after the current position
  assert_adj_ahead_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_valid && !wrap) |-> ({1'b0, adj_len} > ({1'b0, phase_cnt} + 1'b1)));
  // R1: the phase counter never runs past the cycle length
  assert_phase_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    phase_cnt < cur_len);
endmodule

// File: rtl/sw_sync_seq.sv
`timescale 1ns/1ps
// Switching-clock synchronization sequencer (top).
module sw_sync_seq
  import sw_sync_pkg::*;
#(
  parameter int CNT_W          = 16,
  parameter int SYNC_STAGES    = 2,
  parameter int DETECT_EDGES   = 4,
  parameter int HANDOVER_EDGES = 2048,
  parameter int LOSS_PERIODS   = 4,
  parameter int STEP_SHIFT     = 5,
  parameter int LOCK_TOL       = 2,
  parameter int LOCK_CYCLES    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic [CNT_W-1:0] default_period,
  input  logic             reduced_freq,
  output logic             sw_pulse,
  output logic             ss_en,
  output logic             locked,
  output logic [2:0]       state_code
);
  localparam int EW  = $clog2(HANDOVER_EDGES + 1);
  localparam int LCW = $clog2(LOCK_CYCLES + 1);
  localparam int PW  = 2 * CNT_W + 2;

  seq_state_e       state;
  logic [EW-1:0]    edge_cnt;
  logic [LCW-1:0]   lock_cnt;
  logic [CNT_W-1:0] sync_len;

  logic             rise, lost, wrap;
  logic [CNT_W-1:0] meas_period, phase_cnt, cur_len;
  logic [CNT_W-1:0] next_len, adj_len;
  logic             adj_valid;

  sync_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .d_in(sync_in), .rise(rise));

  sync_period_meter #(.CNT_W(CNT_W), .LOSS_PERIODS(LOSS_PERIODS)) u_meter (
    .clk(clk), .rst_n(rst_n), .rise(rise), .default_period(default_period),
    .meas_period(meas_period), .lost(lost));

  sw_pulse_gen #(.CNT_W(CNT_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .next_len(next_len), .adj_valid(adj_valid),
    .adj_len(adj_len), .phase_cnt(phase_cnt), .cur_len(cur_len),
    .wrap(wrap), .sw_pulse(sw_pulse));

  // ---------------- handover cycle length ----------------
  logic [PW-1:0]    ho_prod, ho_rem, ho_sum;
  logic [CNT_W-1:0] ho_len;

  always_comb begin
    ho_prod = PW'(meas_period) * (PW'(cur_len) - PW'(phase_cnt) - PW'(1));
    ho_rem  = ho_prod / PW'(cur_len);
    ho_sum  = PW'(phase_cnt) + PW'(1) + ((ho_rem == '0) ? PW'(1) : ho_rem);
    ho_len  = CNT_W'(ho_sum);
  end

  // ---------------- phase correction ----------------
  logic [CNT_W-1:0] step_cap, half_len, late_err, err_mag, corr_len;
  logic             corr_valid;

  always_comb begin
    step_cap   = ((sync_len >> STEP_SHIFT) == '0) ? CNT_W'(1) : (sync_len >> STEP_SHIFT);
    half_len   = cur_len >> 1;
    late_err   = cur_len - phase_cnt;
    err_mag    = (phase_cnt <= half_len) ? phase_cnt : late_err;
    corr_valid = 1'b0;
    corr_len   = cur_len;
    if (phase_cnt == '0) begin
      corr_valid = 1'b0;
    end else if (phase_cnt <= half_len) begin
      corr_valid = 1'b1;
      corr_len   = cur_len + ((phase_cnt < step_cap) ? phase_cnt : step_cap);
    end else if (late_err > CNT_W'(2)) begin
      corr_valid = 1'b1;
      corr_len   = cur_len - (((late_err - CNT_W'(2)) < step_cap) ? (late_err - CNT_W'(2)) : step_cap);
    end
  end

  // ---------------- handover / adjust steering ----------------
  logic tracking, ho_now, count_done;

  assign tracking   = (state == ST_PHASE) || (state == ST_LOCKED);
  assign count_done = (edge_cnt == EW'(HANDOVER_EDGES - 1));
  assign ho_now     = (state == ST_WAIT) && rise && count_done && !reduced_freq && !lost;
  assign adj_valid  = !wrap && (ho_now || (tracking && rise && corr_valid && !lost));
  assign adj_len    = ho_now ? ho_len : corr_len;
  assign next_len   = ho_now ? meas_period : (tracking ? sync_len : default_period);

  // ---------------- sequencer ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      edge_cnt <= '0;
      lock_cnt <= '0;
      sync_len <= '0;
    end else if (lost && state != ST_IDLE) begin
      state    <= ST_IDLE;
      edge_cnt <= '0;
      lock_cnt <= '0;
    end else if (rise) begin
      unique case (state)
        ST_IDLE: begin
          state    <= ST_DETECT;
          edge_cnt <= EW'(1);
        end
        ST_DETECT: begin
          if (edge_cnt == EW'(DETECT_EDGES - 1)) begin
            state    <= ST_WAIT;
            edge_cnt <= '0;
          end else begin
            edge_cnt <= edge_cnt + 1'b1;
          end
        end
        ST_WAIT: begin
          if (ho_now) begin
            state    <= ST_PHASE;
            sync_len <= meas_period;
            lock_cnt <= '0;
          end else if (!count_done) begin
            edge_cnt <= edge_cnt + 1'b1;
          end
        end
        ST_PHASE: begin
          if (err_mag <= CNT_W'(LOCK_TOL)) begin
            if (lock_cnt == LCW'(LOCK_CYCLES - 1)) state <= ST_LOCKED;
            else lock_cnt <= lock_cnt + 1'b1;
          end else begin
            lock_cnt <= '0;
          end
        end
        default: state <= state;
      endcase
    end
  end

  assign ss_en      = (state == ST_DETECT) || (state == ST_WAIT);
  assign locked     = (state == ST_LOCKED);
  assign state_code = state;

  // R2: the first edge in idle starts detection with spread spectrum on
  assert_first_edge_ss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && rise) |=> (ss_en && state == ST_DETECT));
  // R5: spread spectrum only drops at the handover or on loss of sync
  assert_ss_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ss_en) |-> (state == ST_PHASE || state == ST_IDLE));
  // R6: the handover cycle lies between the old and new periods
  assert_handover_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_valid && state == ST_WAIT) |->
      (adj_len >= ((cur_len < meas_period) ? cur_len : meas_period)) &&
      (adj_len <= ((cur_len > meas_period) ? cur_len : meas_period)));
  // R7: one correction moves the cycle length by at most the step cap
  assert_step_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_valid && tracking) |->
      (({1'b0, adj_len} <= ({1'b0, cur_len} + {1'b0, step_cap})) &&
       (({1'b0, adj_len} + {1'b0, step_cap}) >= {1'b0, cur_len})));
  // R9: a held reduced-frequency flag blocks the handover
  assert_hold_reduced_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && reduced_freq) |=> (state != ST_PHASE));
  // R10: a silent sync input forces the idle state and clears lock
  assert_loss_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lost && state != ST_IDLE) |=> (state == ST_IDLE && !locked));
endmodule

// File: tb/sw_sync_seq_tb_top.sv
`timescale 1ns/1ps
module sw_sync_seq_tb_top;
  localparam int CW   = 16;
  localparam int HE   = 32;
  localparam int DEFP = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sync_in = 1'b0;
  logic          reduced_freq = 1'b0;
  logic [CW-1:0] default_period = CW'(DEFP);
  logic          sw_pulse, ss_en, locked;
  logic [2:0]    state_code;

  sw_sync_seq #(.CNT_W(CW), .HANDOVER_EDGES(HE)) dut_i (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .default_period(default_period),
    .reduced_freq(reduced_freq), .sw_pulse(sw_pulse), .ss_en(ss_en),
    .locked(locked), .state_code(state_code));

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  int last_sw = -1, prev_sw = -1, last_int = 0, bad_int = 0;
  int lo_b = 0, hi_b = 1 << 20;
  bit done = 1'b0;

  // interval monitor: every switching interval must respect the R6/R7 bounds
  always @(negedge clk) begin
    if (rst_n && sw_pulse) begin
      if (prev_sw >= 0) begin
        last_int = cyc - prev_sw;
        if (last_int < lo_b || last_int > hi_b) bad_int++;
      end
      prev_sw = cyc;
      last_sw = cyc;
    end
  end

  function automatic int exp_cap(int p);
    return ((p >> 5) == 0) ? 1 : (p >> 5);
  endfunction
  function automatic int lo_bound(int a, int b);
    return ((a < b) ? a : b) - exp_cap(b);
  endfunction
  function automatic int hi_bound(int a, int b);
    return ((a > b) ? a : b) + exp_cap(b);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    prev_sw = -1;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic sync_pulses(input int n, input int p);
    for (int i = 0; i < n; i++) begin
      sync_in = 1'b1;
      repeat (p / 2) @(negedge clk);
      sync_in = 1'b0;
      repeat (p - p / 2) @(negedge clk);
    end
  endtask

  // one sync edge with an alignment check (R8): pulse expected at edge cycle + 2
  task automatic aligned_pulse(input int p);
    int c;
    c = cyc;
    sync_in = 1'b1;
    repeat (5) @(negedge clk);
    chk((last_sw >= c) && (last_sw <= c + 4), "R8 alignment", last_sw, c + 2);
    repeat (p / 2 - 5) @(negedge clk);
    sync_in = 1'b0;
    repeat (p - p / 2) @(negedge clk);
  endtask

  initial begin
    int unsigned seed_v;
    int p;
    seed_v = $urandom(32'd5501);
    @(negedge clk);

    // ---------- run A: random sync period longer than default ----------
    p = 44 + int'($urandom % 27);
    lo_b = lo_bound(DEFP, p);
    hi_b = hi_bound(DEFP, p);
    do_reset();
    chk(state_code == 3'd0, "R11 reset state", int'(state_code), 0);
    chk(!ss_en && !locked, "R1 reset outputs", int'({ss_en, locked}), 0);
    repeat (5 * DEFP) @(negedge clk);
    chk(last_int == DEFP, "R1 default period", last_int, DEFP);
    repeat (int'($urandom % DEFP)) @(negedge clk);

    sync_pulses(1, p);
    chk(state_code == 3'd1, "R2 first edge state", int'(state_code), 1);
    chk(ss_en, "R2 ss_en on first edge", int'(ss_en), 1);
    sync_pulses(2, p);
    chk(state_code == 3'd1, "R3 three edges", int'(state_code), 1);
    sync_pulses(1, p);
    chk(state_code == 3'd2, "R3 fourth edge", int'(state_code), 2);
    chk(ss_en, "R5 ss_en while counting", int'(ss_en), 1);
    sync_pulses(HE - 1, p);
    chk(state_code == 3'd2, "R4 before handover", int'(state_code), 2);
    sync_pulses(1, p);
    chk(state_code == 3'd3, "R4 handover", int'(state_code), 3);
    chk(!ss_en, "R5 ss_en off at handover", int'(ss_en), 0);

    for (int i = 0; i < 80 && !locked; i++) sync_pulses(1, p);
    chk(locked && state_code == 3'd4, "R8 lock reached", int'(state_code), 4);
    for (int i = 0; i < 6; i++) aligned_pulse(p);
    chk(last_int == p, "R8 locked period", last_int, p);
    chk(bad_int == 0, "R6 R7 interval bounds run A", bad_int, 0);

    // loss of sync after lock
    repeat (4 * DEFP + 20) @(negedge clk);
    chk(state_code == 3'd0, "R10 loss state", int'(state_code), 0);
    chk(!locked && !ss_en, "R10 loss outputs", int'({locked, ss_en}), 0);
    repeat (3 * DEFP) @(negedge clk);
    chk(last_int == DEFP, "R10 default period restored", last_int, DEFP);
    sync_pulses(3, p);
    chk(state_code == 3'd1, "R10 detection restarts", int'(state_code), 1);
    sync_pulses(1, p);
    chk(state_code == 3'd2, "R10 four fresh edges", int'(state_code), 2);

    // ---------- run B: directed short sync period, reduced-frequency hold ----------
    p = 32;
    lo_b = lo_bound(DEFP, p);
    hi_b = hi_bound(DEFP, p);
    do_reset();
    reduced_freq = 1'b1;
    repeat (7) @(negedge clk);
    sync_pulses(4, p);
    chk(state_code == 3'd2, "R3 run B counting", int'(state_code), 2);
    sync_pulses(HE + 6, p);
    chk(state_code == 3'd2, "R9 hold while reduced", int'(state_code), 2);
    chk(ss_en, "R9 ss_en still on", int'(ss_en), 1);
    reduced_freq = 1'b0;
    sync_pulses(1, p);
    chk(state_code == 3'd3, "R9 handover after clear", int'(state_code), 3);
    for (int i = 0; i < 80 && !locked; i++) sync_pulses(1, p);
    chk(locked, "R8 lock run B", int'(locked), 1);
    for (int i = 0; i < 4; i++) aligned_pulse(p);
    chk(bad_int == 0, "R6 R7 interval bounds run B", bad_int, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule